// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block sits behind a receive deserializer and sees one frame at a time as a byte stream. The stream starts with the first destination address byte, which is the byte right after the start delimiter, and ends with the last checksum byte. A start marker comes with the first byte and an end marker with the last. The block compares the destination address with a programmed station address, one byte per cycle. It abandons a frame at the first byte that differs.

For a frame that matches, the block reads the two-byte length field. It forwards exactly that many payload bytes and discards any padding up to the checksum. The whole frame runs through a CRC-32 in parallel. When the frame ends, the block raises a one-cycle good or bad flag.

A downstream consumer writes the forwarded bytes tentatively. It keeps them on the good pulse and rolls them back on the bad pulse, because payload can leave the block before the checksum has been judged.

Top module: `eth_rx_filter`

## Requirements
- R1: While rst_n is low and on the first cycles after its release with no input, pay_valid, frame_good, frame_bad and frame_drop are 0.
- R2: Frame byte k, for k from 0 to 5, is compared with station_addr[47-8k -: 8], so byte 0 is compared with the top octet. On the first byte that differs, frame_drop is high for exactly one cycle, in the cycle after that byte is accepted.
- R3: After a drop, the block ignores every byte up to the next in_sof. No pay_valid, frame_good or frame_bad comes from the dropped frame, even when its end marker arrives.
- R4: Byte 12 is the high octet of the length L and byte 13 the low octet. Frame bytes 14 to 14+L-1 appear on pay_byte with pay_valid, in order. Each appears one cycle after it is accepted.
- R5: Bytes after the L counted payload bytes are not forwarded. Zero-length payloads are included.
- R6: The CRC is the reflected CRC-32 with polynomial 0xEDB88320 and initial value all ones. The transmitted checksum is the complement of the register, sent low octet first. If the check over the whole frame fails, frame_bad pulses in the cycle after the end byte.
- R7: If L is greater than 1500, no payload byte is forwarded and frame_bad pulses after the end byte.
- R8: A frame with fewer than 64 bytes, counted from byte 0 through the last checksum byte, gets frame_bad. A frame of exactly 64 bytes is not short.
- R9: A matched frame that breaks none of R6 to R8 gets frame_good for one cycle after its end byte. At most one of frame_good, frame_bad and frame_drop is high in any cycle.
- R10: Cycles with in_valid low change nothing. Forwarding and the final verdict are the same as for the same bytes sent back to back.
- R11: in_sof restarts reception at byte 0 even in the middle of a frame. The abandoned frame produces no good or bad pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| station_addr | input | 48 | Own address; bits 47:40 are matched against the first byte |
| in_valid | input | 1 | in_byte carries a frame byte this cycle |
| in_byte | input | 8 | Received byte |
| in_sof | input | 1 | This byte is frame byte 0 |
| in_eof | input | 1 | This byte is the last checksum byte |
| pay_valid | output | 1 | pay_byte holds a payload byte |
| pay_byte | output | 8 | Forwarded payload byte |
| frame_good | output | 1 | One-cycle pulse: frame accepted |
| frame_bad | output | 1 | One-cycle pulse: frame rejected, discard its payload |
| frame_drop | output | 1 | One-cycle pulse: destination mismatch, frame abandoned |

## Verification
A byte counter that has slipped moves the comparison window. The drop pulse then lands on the wrong byte, and payload starts or stops one position off. Both show within one cycle at pay_valid and frame_drop, and the bench checks each forwarded byte against its expected value and position. A corrupted CRC register or a missed restart on in_sof stays hidden until the end marker. There it flips frame_good to frame_bad, so the bench checks the verdict on every frame, including frames sent with idle gaps and frames restarted mid-stream.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_ADDR = 2'd1,
    RX_BODY = 2'd2,
    RX_DROP = 2'd3
  } rx_state_e;

  localparam int ADDR_BYTES  = 6;
  localparam int LEN_HI_POS  = 12;
  localparam int LEN_LO_POS  = 13;
  localparam int HDR_BYTES   = 14;
  localparam int FCS_BYTES   = 4;
  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;
endpackage

// File: rtl/eth_rx_crc.sv
module eth_rx_crc #(
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        restart,
  input  logic [7:0]  data,
  output logic [31:0] crc_next
);
  logic [31:0] crc_q;

  // LSB-first byte update of the reflected register
  always_comb begin
    logic [31:0] c;
    c = restart ? 32'hFFFF_FFFF : crc_q;
    c = c ^ {24'd0, data};
    for (int b = 0; b < 8; b++) begin
      if (c[0]) c = {1'b0, c[31:1]} ^ POLY;
      else      c = {1'b0, c[31:1]};
    end
    crc_next = c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= 32'hFFFF_FFFF;
    else if (en) crc_q <= crc_next;
  end
endmodule

// File: rtl/eth_rx_addr_cmp.sv
module eth_rx_addr_cmp #(
  parameter int NBYTES = 6,
  localparam int SEL_W = $clog2(NBYTES)
) (
  input  logic [8*NBYTES-1:0] station_addr,
  input  logic [SEL_W-1:0]    sel,
  input  logic [7:0]          data,
  output logic                hit
);
  logic [7:0] octet [NBYTES];

  // octet[0] is the most significant byte, received first
  for (genvar g = 0; g < NBYTES; g++) begin : g_oct
    assign octet[g] = station_addr[8*(NBYTES-g)-1 -: 8];
  end

  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NBYTES; k++) begin
      if (sel == SEL_W'(k)) hit = (octet[k] == data);
    end
  end
endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
  import eth_rx_pkg::*;
#(
  parameter int MAX_PAYLOAD = 1500,
  parameter int MIN_FRAME   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] station_addr,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        pay_valid,
  output logic [7:0]  pay_byte,
  output logic        frame_good,
  output logic        frame_bad,
  output logic        frame_drop
);
  localparam int CNT_W = $clog2(HDR_BYTES + MAX_PAYLOAD + FCS_BYTES + 1) + 1;
  localparam int SEL_W = $clog2(ADDR_BYTES);
  localparam logic [CNT_W-1:0] IDX_ADDR_END = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] IDX_ADDR_LST = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] IDX_LEN_HI   = CNT_W'(LEN_HI_POS);
  localparam logic [CNT_W-1:0] IDX_LEN_LO   = CNT_W'(LEN_LO_POS);
  localparam logic [CNT_W-1:0] IDX_HDR      = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] IDX_MIN_LAST = CNT_W'(MIN_FRAME - 1);
  localparam logic [CNT_W-1:0] CNT_MAX      = {CNT_W{1'b1}};
  localparam logic [15:0]      LEN_LIMIT    = 16'(MAX_PAYLOAD);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cur_idx;
  logic [15:0]      len_q, len_d;
  logic             take, miss, byte_hit, fwd, fin, bad_now;
  logic             len_ok, is_short, crc_fail;
  logic [31:0]      crc_next;
  logic [16:0]      pay_lim;

  eth_rx_addr_cmp #(.NBYTES(ADDR_BYTES)) i_addr_cmp (
    .station_addr (station_addr),
    .sel          (cur_idx[SEL_W-1:0]),
    .data         (in_byte),
    .hit          (byte_hit)
  );

  eth_rx_crc #(.POLY(CRC_POLY)) i_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (take),
    .restart  (in_sof),
    .data     (in_byte),
    .crc_next (crc_next)
  );

  // next-state logic
  always_comb begin
    take    = in_valid && (in_sof || state_q == RX_ADDR || state_q == RX_BODY);
    cur_idx = in_sof ? '0 : cnt_q;
    miss    = take && (cur_idx < IDX_ADDR_END) && !byte_hit;
    len_ok  = (len_q <= LEN_LIMIT);
    pay_lim = 17'(HDR_BYTES) + {1'b0, len_q};
    fwd     = take && !miss && (cur_idx >= IDX_HDR) && len_ok &&
              ({{(17-CNT_W){1'b0}}, cur_idx} < pay_lim);
    fin     = take && in_eof && !miss;

    crc_fail = (crc_next != CRC_RESIDUE);
    is_short = (cur_idx < IDX_MIN_LAST);
    bad_now  = crc_fail || is_short || ((cur_idx > IDX_LEN_LO) && !len_ok);

    state_d = state_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    if (take) begin
      cnt_d = (cur_idx == CNT_MAX) ? cur_idx : cur_idx + CNT_W'(1);
      if (miss)                         state_d = RX_DROP;
      else if (in_eof)                  state_d = RX_IDLE;
      else if (cur_idx == IDX_ADDR_LST) state_d = RX_BODY;
      else if (in_sof)                  state_d = RX_ADDR;
      if (cur_idx == IDX_LEN_HI) len_d[15:8] = in_byte;
      if (cur_idx == IDX_LEN_LO) len_d[7:0]  = in_byte;
    end
  end

  // state registers, enabled by accepted bytes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
    end else if (in_valid) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
    end
  end

  // output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_valid  <= 1'b0;
      pay_byte   <= '0;
      frame_good <= 1'b0;
      frame_bad  <= 1'b0;
      frame_drop <= 1'b0;
    end else begin
      pay_valid  <= fwd;
      if (fwd) pay_byte <= in_byte;
      frame_good <= fin && !bad_now;
      frame_bad  <= fin && bad_now;
      frame_drop <= miss;
    end
  end
endmodule

// File: rtl/eth_rx_filter_chk.sv
module eth_rx_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_eof,
  input logic pay_valid,
  input logic frame_good,
  input logic frame_bad,
  input logic frame_drop
);
  assert_verdict_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_good, frame_bad, frame_drop}));

  assert_good_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_good |-> $past(in_valid && in_eof));

  assert_bad_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |-> $past(in_valid && in_eof));

  assert_fwd_needs_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> $past(in_valid));

  assert_drop_no_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |-> !pay_valid);
endmodule

bind eth_rx_filter eth_rx_filter_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_eof     (in_eof),
  .pay_valid  (pay_valid),
  .frame_good (frame_good),
  .frame_bad  (frame_bad),
  .frame_drop (frame_drop)
);

// File: tb/test_eth_rx_filter.sv
`timescale 1ns/1ps
module test_eth_rx_filter;
  localparam logic [47:0] STA = 48'h02_1A_3C_4D_5E_6F;
  // {mis_pos[47:44] (F = none), len[43:28], body[27:16], corrupt[15], gaps[14], exp {drop,bad,good}[2:0]}
  localparam int NV = 12;
  localparam logic [47:0] VEC [NV] = '{
    {4'hF, 16'd46,   12'd46,   1'b0, 1'b0, 11'd0, 3'b001}, // R9 minimum frame good
    {4'hF, 16'd10,   12'd46,   1'b0, 1'b0, 11'd0, 3'b001}, // R5 padding stripped
    {4'hF, 16'd100,  12'd100,  1'b0, 1'b0, 11'd0, 3'b001}, // R4
    {4'h0, 16'd46,   12'd46,   1'b0, 1'b0, 11'd0, 3'b100}, // R2 first byte differs
    {4'h5, 16'd46,   12'd46,   1'b0, 1'b0, 11'd0, 3'b100}, // R2 last address byte differs
    {4'hF, 16'd20,   12'd46,   1'b1, 1'b0, 11'd0, 3'b010}, // R6 corrupt checksum
    {4'hF, 16'd1501, 12'd46,   1'b0, 1'b0, 11'd0, 3'b010}, // R7 length too large
    {4'hF, 16'd10,   12'd10,   1'b0, 1'b0, 11'd0, 3'b010}, // R8 28-byte frame
    {4'hF, 16'd1500, 12'd1500, 1'b0, 1'b0, 11'd0, 3'b001}, // R7 boundary accepted
    {4'hF, 16'd45,   12'd45,   1'b0, 1'b0, 11'd0, 3'b010}, // R8 63-byte frame
    {4'hF, 16'd46,   12'd46,   1'b0, 1'b1, 11'd0, 3'b001}, // R10 idle gaps
    {4'hF, 16'd0,    12'd46,   1'b0, 1'b0, 11'd0, 3'b001}  // R5 zero payload
  };

  logic clk, rst_n, in_valid, in_sof, in_eof;
  logic [7:0] in_byte;
  logic pay_valid, frame_good, frame_bad, frame_drop;
  logic [7:0] pay_byte;

  eth_rx_filter i_eth_rx_filter (
    .clk(clk), .rst_n(rst_n), .station_addr(STA),
    .in_valid(in_valid), .in_byte(in_byte), .in_sof(in_sof), .in_eof(in_eof),
    .pay_valid(pay_valid), .pay_byte(pay_byte),
    .frame_good(frame_good), .frame_bad(frame_bad), .frame_drop(frame_drop)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int n_good, n_bad, n_drop, n_fwd, n_err, drop_at, seen_idx, drv_idx;
  logic [7:0] seed;
  logic [7:0] fr [0:1599];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input logic [7:0] s);
    return 8'(i * 7) + s;
  endfunction

  function automatic logic [31:0] crc_bit(input logic [31:0] c, input logic d);
    logic fb;
    fb = c[0] ^ d;
    c  = c >> 1;
    return fb ? (c ^ 32'hEDB88320) : c;
  endfunction

  // monitor: sample away from the active edge
  always @(negedge clk) begin
    if (frame_good) n_good++;
    if (frame_bad)  n_bad++;
    if (frame_drop) begin n_drop++; drop_at = seen_idx; end
    if (pay_valid) begin
      if (pay_byte !== pat(n_fwd, seed)) n_err++;
      n_fwd++;
    end
    seen_idx = in_valid ? drv_idx : -1;
  end

  task automatic clear_mon(input logic [7:0] s);
    n_good = 0; n_bad = 0; n_drop = 0; n_fwd = 0; n_err = 0; drop_at = -1; seed = s;
  endtask

  task automatic send(input int mis, input int len, input int body, input bit corrupt,
                      input bit gaps, input int stop_at);
    int n;
    logic [31:0] c;
    for (int i = 0; i < 6; i++) fr[i] = STA[47-8*i -: 8] ^ ((i == mis) ? 8'h01 : 8'h00);
    for (int i = 6; i < 12; i++) fr[i] = 8'(8'h10 + i);
    fr[12] = len[15:8];
    fr[13] = len[7:0];
    for (int i = 0; i < body; i++) fr[14+i] = (i < len) ? pat(i, seed) : 8'h00;
    n = 14 + body;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) c = crc_bit(c, fr[i][b]);
    c = ~c;
    if (corrupt) c = c ^ 32'h0000_0100;
    for (int i = 0; i < 4; i++) fr[n+i] = c[8*i +: 8];
    n = n + 4;
    if (stop_at > 0) n = stop_at;
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(posedge clk); #1; in_valid = 0; in_sof = 0; in_eof = 0;
      end
      @(posedge clk); #1;
      in_valid = 1; in_byte = fr[i]; drv_idx = i;
      in_sof = (i == 0);
      in_eof = (i == n - 1) && (stop_at == 0);
    end
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0; in_eof = 0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_sof = 0; in_eof = 0; in_byte = 0; drv_idx = -1;
    clear_mon(8'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 outputs in reset", {pay_valid, frame_good, frame_bad, frame_drop}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 outputs after release", {pay_valid, frame_good, frame_bad, frame_drop}, 0);

    for (int v = 0; v < NV; v++) begin
      int mis, len, body, ef;
      bit exp_drop;
      mis  = (VEC[v][47:44] == 4'hF) ? -1 : int'(VEC[v][47:44]);
      len  = int'(VEC[v][43:28]);
      body = int'(VEC[v][27:16]);
      exp_drop = VEC[v][2];
      ef = (exp_drop || len > 1500) ? 0 : ((len < body) ? len : body);
      clear_mon(8'(v + 3));
      send(mis, len, body, VEC[v][15], VEC[v][14], 0);
      check($sformatf("R9/R6/R8/R3 good count v%0d", v), n_good, int'(VEC[v][0]));
      check($sformatf("R6/R7/R8/R3 bad count v%0d", v), n_bad, int'(VEC[v][1]));
      check($sformatf("R2 drop count v%0d", v), n_drop, int'(VEC[v][2]));
      check($sformatf("R4/R5/R7/R10 forwarded count v%0d", v), n_fwd, ef);
      check($sformatf("R4 payload bytes wrong v%0d", v), n_err, 0);
      if (exp_drop) check($sformatf("R2 drop position v%0d", v), drop_at, mis);
    end

    // R11: abandon a frame mid-way, then a full good frame
    clear_mon(8'd40);
    send(-1, 46, 46, 1'b0, 1'b0, 20);
    send(-1, 46, 46, 1'b0, 1'b0, 0);
    check("R11 good after restart", n_good, 1);
    check("R11 no bad from abandoned frame", n_bad, 0);
    check("R11 forwarded count", n_fwd, 6 + 46);

    // R3: dropped frame then a matching frame is received normally
    clear_mon(8'd50);
    send(2, 46, 46, 1'b0, 1'b0, 0);
    check("R3 dropped frame no verdict", n_good + n_bad, 0);
    check("R3 dropped frame no payload", n_fwd, 0);
    clear_mon(8'd51);
    send(-1, 46, 46, 1'b0, 1'b0, 0);
    check("R3 next frame good", n_good, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule